// File: doc/BRIEF.md
# Grouped Maskable Interrupt Aggregator

This block gathers interrupt requests from an expander's input lines and presents them to a host as one active-low request line. The lines are organised in groups of eight. Each line passes through a two-stage synchronizer. An edge detector then compares each line with its value one cycle earlier. A per-line pair of enables chooses whether rising edges, falling edges, both or neither are recorded. A recorded edge sets a sticky status bit. That bit asks for service only while its mask bit is also set.

Software uses a small word-wide register port. It first reads a group summary word to find which groups hold pending enabled interrupts. It then reads that group's status and mask. It services the source and writes ones to clear the status bits it has handled. Address `{group, sel}` selects a register. For groups 0..NUM_GRP-1, sel 0 is status (write-one-to-clear), sel 1 is mask, sel 2 is the rising-edge enable and sel 3 is the falling-edge enable. Group index NUM_GRP with sel 0 is the read-only summary. Reads use the address in the same cycle and need no clock edge.

Top module: `irq_aggregator`

## Requirements
- R1: While the rising enable of a line is 1 (reset value of every rising-enable word: all ones), a 0-to-1 change on that pin sets its status bit.
- R2: While the falling enable of a line is 1 (reset value all zeros), a 1-to-0 change sets its status bit. With both enables set, either edge sets it. With both clear, no edge sets it.
- R3: A pin change applied before clock edge k is not visible in status after edge k+1 and is visible after edge k+2.
- R4: Writing a status word clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R5: When an edge on a line and a write-one-to-clear of its status bit act on the same clock edge, the bit ends up set.
- R6: irq_n is 0 exactly when some status bit and its mask bit are both 1, and is 1 otherwise.
- R7: After reset all masks, status bits and falling enables read 0, every rising enable reads all ones, and irq_n is 1.
- R8: The summary word (address NUM_GRP*4) has bit g equal to 1 exactly when group g has a status bit whose mask bit is 1. Writes to it change no register.
- R9: Status bits are set and held regardless of their mask. A status bit changes from 1 to 0 only by a clearing write.
- R10: Reads of an address that maps to no register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_GRP*GRP_W | Asynchronous interrupt source lines, group g at bits g*GRP_W upward |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address {group, sel} |
| reg_wdata | input | GRP_W | Write data |
| reg_rdata | output | GRP_W | Read data for reg_addr, combinational |
| irq_n | output | 1 | Active-low aggregated interrupt request |

## Verification
Single rising changes on lines in different groups show that edges reach status with the stated latency and land in the right group and bit position. Falling changes run under rising-only, falling-only and both-edge enables, which separates the two edge polarities. Clearing writes with mixed one and zero patterns show whether a zero bit is left alone. A clear timed onto the cycle an edge is recorded shows which one wins. Pending status is checked with its mask off and then on, which separates latching from gating of irq_n and the summary word.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NUM_GRP = 3,
  parameter int GRP_W   = 8,
  localparam int N      = NUM_GRP * GRP_W,
  localparam int GW     = $clog2(NUM_GRP + 1),
  localparam int AW     = GW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pin_i,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [GRP_W-1:0] reg_wdata,
  output logic [GRP_W-1:0] reg_rdata,
  output logic          irq_n
);

  logic [N-1:0] sync1, sync2, prev;
  logic [N-1:0] status_q, mask_q, rise_q, fall_q;
  logic [N-1:0] hit, clr;
  logic [NUM_GRP-1:0] grp_stat;

  wire [GW-1:0] a_grp = reg_addr[AW-1:2];
  wire [1:0]    a_sel = reg_addr[1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= pin_i;
      sync2 <= sync1;
      prev  <= sync2;
    end

  assign hit = (rise_q & sync2 & ~prev) | (fall_q & ~sync2 & prev);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    wire sel_g = reg_we && (a_grp == GW'(g));

    assign clr[g*GRP_W +: GRP_W] = (sel_g && a_sel == 2'd0) ? reg_wdata : '0;
    assign grp_stat[g] = |(status_q[g*GRP_W +: GRP_W] & mask_q[g*GRP_W +: GRP_W]);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        mask_q[g*GRP_W +: GRP_W] <= '0;
        rise_q[g*GRP_W +: GRP_W] <= '1;
        fall_q[g*GRP_W +: GRP_W] <= '0;
      end else if (sel_g) begin
        if (a_sel == 2'd1) mask_q[g*GRP_W +: GRP_W] <= reg_wdata;
        if (a_sel == 2'd2) rise_q[g*GRP_W +: GRP_W] <= reg_wdata;
        if (a_sel == 2'd3) fall_q[g*GRP_W +: GRP_W] <= reg_wdata;
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr) | hit;

  assign irq_n = ~|grp_stat;

  always_comb begin
    reg_rdata = '0;
    for (int g = 0; g < NUM_GRP; g++)
      if (a_grp == GW'(g))
        case (a_sel)
          2'd0: reg_rdata = status_q[g*GRP_W +: GRP_W];
          2'd1: reg_rdata = mask_q[g*GRP_W +: GRP_W];
          2'd2: reg_rdata = rise_q[g*GRP_W +: GRP_W];
          default: reg_rdata = fall_q[g*GRP_W +: GRP_W];
        endcase
    if (a_grp == GW'(NUM_GRP) && a_sel == 2'd0)
      reg_rdata[NUM_GRP-1:0] = grp_stat;
  end

  // R1 / R2 / R5: a recorded edge always leaves its bit set, clear or not
  assert_edge_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((status_q & $past(hit)) == $past(hit)));

  // R9: without a clearing write no status bit falls
  assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && a_sel == 2'd0 && a_grp < GW'(NUM_GRP))
    |=> ((status_q & $past(status_q)) == $past(status_q)));

  assert_quiet_after_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> irq_n);

  assert_summary_readonly_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && a_grp == GW'(NUM_GRP))
    |=> ($stable(mask_q) && $stable(rise_q) && $stable(fall_q)));

endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  localparam int NUM_GRP = 3;
  localparam int GRP_W   = 8;
  localparam int N       = NUM_GRP * GRP_W;
  localparam int AW      = $clog2(NUM_GRP + 1) + 2;

  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [N-1:0] pin_i = '0;
  logic [AW-1:0] reg_addr = '0;
  logic [GRP_W-1:0] reg_wdata = '0, reg_rdata;
  logic irq_n;
  int checks = 0, fails = 0;

  irq_aggregator #(.NUM_GRP(NUM_GRP), .GRP_W(GRP_W)) i_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n));

  always #10 clk = ~clk;

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(int addr, int data);
    @(negedge clk);
    reg_we = 1; reg_addr = AW'(addr); reg_wdata = GRP_W'(data);
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(int addr, output int val);
    reg_addr = AW'(addr);
    #1 val = int'(reg_rdata);
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    int v;
    rd(0, v); check("R7 status", v, 0);
    rd(1, v); check("R7 mask", v, 0);
    rd(2, v); check("R7 rise enable", v, 8'hFF);
    rd(3, v); check("R7 fall enable", v, 0);
    check("R7 irq_n", int'(irq_n), 1);
    rd(13, v); check("R10 unmapped read", v, 0);
  endtask

  task automatic t_rise_latency();
    int v;
    @(negedge clk); pin_i[0] = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rd(0, v); check("R3 not yet after edge k+1", v, 0);
    @(posedge clk); @(negedge clk);
    rd(0, v); check("R1 R3 set after edge k+2", v, 8'h01);
  endtask

  task automatic t_falling();
    int v;
    wr(0, 8'hFF);
    @(negedge clk); pin_i[0] = 0; settle();
    rd(0, v); check("R2 fall ignored when disabled", v, 0);
    wr(2, 8'h04); wr(3, 8'h06);
    @(negedge clk); pin_i[1] = 1; settle();
    rd(0, v); check("R2 rise ignored on fall-only line", v, 0);
    @(negedge clk); pin_i[1] = 0; settle();
    rd(0, v); check("R2 fall sets on fall-only line", v, 8'h02);
    @(negedge clk); pin_i[2] = 1; settle();
    rd(0, v); check("R2 both-edge line rise", v, 8'h06);
  endtask

  task automatic t_w1c();
    int v;
    wr(0, 8'h02);
    rd(0, v); check("R4 clear of written one", v, 8'h04);
    wr(0, 8'h00);
    rd(0, v); check("R4 zero write leaves bits", v, 8'h04);
    @(negedge clk); pin_i[2] = 0; settle();
    rd(0, v); check("R2 both-edge line fall", v, 8'h04);
    wr(0, 8'h04);
    rd(0, v); check("R4 cleared", v, 0);
  endtask

  task automatic t_mask();
    int v;
    @(negedge clk); pin_i[8] = 1; settle();
    rd(4, v); check("R9 latched while masked", v, 8'h01);
    check("R6 irq_n high while masked", int'(irq_n), 1);
    rd(12, v); check("R8 summary masked", v, 0);
    wr(5, 8'h01);
    #1 check("R6 irq_n low when enabled", int'(irq_n), 0);
    rd(12, v); check("R8 summary group 1", v, 8'h02);
    wr(12, 8'hFF);
    rd(12, v); check("R8 summary write ignored", v, 8'h02);
    rd(5, v); check("R8 mask untouched", v, 8'h01);
    rd(2, v); check("R8 rise enable untouched", v, 8'h04);
    wr(4, 8'h01);
    #1 check("R6 irq_n high after clear", int'(irq_n), 1);
  endtask

  task automatic t_collision();
    int v;
    wr(11, 8'h01);
    @(negedge clk); pin_i[16] = 1; settle();
    rd(8, v); check("R1 group 2 rise", v, 8'h01);
    @(negedge clk); pin_i[16] = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    reg_we = 1; reg_addr = AW'(8); reg_wdata = 8'h01;
    @(negedge clk); reg_we = 0;
    rd(8, v); check("R5 edge wins over clear", v, 8'h01);
    wr(8, 8'h01);
    rd(8, v); check("R4 later clear", v, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_rise_latency();
    t_falling();
    t_w1c();
    t_mask();
    t_collision();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule